// File: doc/BRIEF.md
# Input-Port Multicast Virtual-Channel Arbiter

This block sits at one input port of a five-port mesh router and forms the first stage of a separable switch allocator. The port holds six virtual channels (VCs). VCs 0 to 3 belong to the request class: each is one flit deep and carries one-flit packets. VCs 4 and 5 belong to the response class: each is three flits deep and carries five-flit packets. The two classes use separate VCs so that message-level deadlock cannot occur. The block stores no flit data. For each VC it keeps the output-port set of the packet it holds, its occupancy, and how many flits have arrived and left.

Each cycle a round-robin picker chooses one occupied VC and presents that VC's pending output-port vector to the output-side allocator. The vector is a 5-bit multi-hot set with bit 0 for North, 1 for East, 2 for South, 3 for West and 4 for the local interface. A flit may ask for several ports at once. The allocator returns the ports it granted in the same cycle. A multicast flit stays at the head of its VC until every port it asked for has been served. The block announces a VC as free for reuse only when the packet's last flit leaves.

Flits enter on a valid/ready handshake: a flit transfers on a clock edge where `in_vld` and `in_rdy` are both high, and an upstream flit held with `in_rdy` low must stay stable. The request side has no ready signal of its own. The grant vector is its only back-pressure: a request with no granted bit is simply presented again.

Top module: `vc_mcast_arb`

## Requirements
- R1: After reset no VC holds a flit: `req_vld` and `rel_vld` are low and `in_rdy` is high for every VC number.
- R2: A flit is accepted into VC `in_vc` when `in_vld` and `in_rdy` are both high at a clock edge. The first flit into an idle VC is the head, and its `in_route` becomes the port set for the whole packet.
- R3: From the cycle after a VC receives a flit, that VC can be selected. When selected, `req_vld` is high, `req_vc` names it and `req_ports` shows its pending port bits.
- R4: Selection is round-robin. The search starts at the VC after the last VC that received a grant, and after reset it starts at VC 0.
- R5: The round-robin pointer moves to the selected VC only when that VC receives at least one of its requested ports. With no such grant and no new arrival, the next cycle presents the same VC and the same vector.
- R6: A grant that covers only some requested bits clears those bits. The flit stays, and later requests from that VC show only the remaining bits.
- R7: Bits of `gnt_ports` outside `req_ports` have no effect.
- R8: A flit leaves when its remaining bits are all granted. The next flit of the same response packet then asks again for the packet's full port set.
- R9: `rel_vld` pulses, with `rel_vc` naming the VC, in the same cycle that the grant completing a packet's last flit is given. This happens after every request-class flit and after the fifth response-class flit.
- R10: `in_rdy` is low for a VC that is full (1 flit for VCs 0 to 3, 3 flits for VCs 4 and 5) or that has already received all flits of its packet (1 or 5). A flit offered while `in_rdy` is low is ignored.
- R11: `req_ports` is never zero while `req_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Incoming flit valid |
| in_rdy | output | 1 | Target VC can take the flit |
| in_vc | input | 3 | Target VC of the incoming flit |
| in_route | input | 5 | Output-port set (meaningful on head flits) |
| req_vld | output | 1 | A VC is requesting output ports |
| req_vc | output | 3 | Selected VC |
| req_ports | output | 5 | Pending output-port bits of the selected VC |
| gnt_ports | input | 5 | Ports granted this cycle by the output stage |
| rel_vld | output | 1 | A VC finished its packet and is free |
| rel_vc | output | 3 | VC being released |

## Verification
A flit accepted at an edge first shows on the request outputs in the cycle after that edge. A grant acts on `req_ports` and `rel_vld` within the same cycle it is given, and shows on the pointer and the remaining bits from the next cycle on. The bench drives each stimulus one nanosecond after a rising edge and compares every expected item at the following falling edge. Each comparison therefore sees the state left by the previous edge combined with the current grant, which matches these latencies exactly.

// File: rtl/noc_vca_pkg.sv
package noc_vca_pkg;
  localparam int VCA_PORTS    = 5;
  localparam int VCA_REQ_VCS  = 4;
  localparam int VCA_RSP_VCS  = 2;
  localparam int VCA_REQ_DEP  = 1;
  localparam int VCA_RSP_DEP  = 3;
  localparam int VCA_REQ_LEN  = 1;
  localparam int VCA_RSP_LEN  = 5;
  localparam int VCA_NUM_VC   = VCA_REQ_VCS + VCA_RSP_VCS;
  localparam int VCA_VC_W     = $clog2(VCA_NUM_VC);
endpackage

// File: rtl/vca_vc_slot.sv
// Book-keeping for one virtual channel: occupancy, packet progress and
// the output ports still owed to its head flit.
module vca_vc_slot #(
  parameter int PORTS   = 5,
  parameter int DEPTH   = 1,
  parameter int PKT_LEN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PORTS-1:0] push_route,
  input  logic [PORTS-1:0] served,
  output logic             has_flit,
  output logic [PORTS-1:0] pending,
  output logic             accept_ok,
  output logic             pkt_done
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(PKT_LEN + 1);

  logic             busy;
  logic [OCC_W-1:0] occ;
  logic [IDX_W-1:0] arrived;
  logic [IDX_W-1:0] sent;
  logic [PORTS-1:0] route;
  logic [PORTS-1:0] rem;
  logic             flit_done;

  assign has_flit  = (occ != '0);
  assign pending   = has_flit ? rem : '0;
  assign accept_ok = (occ < OCC_W'(DEPTH)) && (arrived < IDX_W'(PKT_LEN));
  assign flit_done = has_flit && (served != '0) && ((rem & ~served) == '0);
  assign pkt_done  = flit_done && (sent == IDX_W'(PKT_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      occ     <= '0;
      arrived <= '0;
      sent    <= '0;
      route   <= '0;
      rem     <= '0;
    end else begin
      occ <= occ + OCC_W'(push) - OCC_W'(flit_done);
      if (pkt_done) begin
        busy    <= 1'b0;
        arrived <= '0;
        sent    <= '0;
      end else begin
        if (push) begin
          arrived <= arrived + 1'b1;
          if (!busy) begin
            busy  <= 1'b1;
            route <= push_route;
          end
        end
        if (flit_done) sent <= sent + 1'b1;
      end
      if (push && !busy)  rem <= push_route;
      else if (flit_done) rem <= route;
      else                rem <= rem & ~served;
    end
  end
endmodule

// File: rtl/vca_rr_pick.sv
// Round-robin chooser: searches from the entry after the last served one.
module vca_rr_pick #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic             found,
  output logic [IDX_W-1:0] win_idx
);
  logic [IDX_W-1:0] last;

  always_comb begin
    int c;
    found   = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(last) + k) % N;
      if (!found && req[c]) begin
        found   = 1'b1;
        win_idx = IDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last <= IDX_W'(N - 1);
    else if (advance) last <= win_idx;
  end
endmodule

// File: rtl/vc_mcast_arb.sv
module vc_mcast_arb
  import noc_vca_pkg::*;
#(
  parameter int PORTS    = VCA_PORTS,
  parameter int REQ_VCS  = VCA_REQ_VCS,
  parameter int RSP_VCS  = VCA_RSP_VCS,
  parameter int REQ_DEP  = VCA_REQ_DEP,
  parameter int RSP_DEP  = VCA_RSP_DEP,
  parameter int REQ_LEN  = VCA_REQ_LEN,
  parameter int RSP_LEN  = VCA_RSP_LEN,
  parameter int VC_W     = VCA_VC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  output logic             in_rdy,
  input  logic [VC_W-1:0]  in_vc,
  input  logic [PORTS-1:0] in_route,
  output logic             req_vld,
  output logic [VC_W-1:0]  req_vc,
  output logic [PORTS-1:0] req_ports,
  input  logic [PORTS-1:0] gnt_ports,
  output logic             rel_vld,
  output logic [VC_W-1:0]  rel_vc
);
  localparam int NVC = REQ_VCS + RSP_VCS;

  logic [NVC-1:0]   has_flit, accept_ok, pkt_done, push;
  logic [PORTS-1:0] pending [NVC];
  logic [PORTS-1:0] eff_gnt;
  logic             found, advance;
  logic [VC_W-1:0]  win;

  always_comb begin
    in_rdy = 1'b0;
    for (int v = 0; v < NVC; v++)
      if (in_vc == VC_W'(v)) in_rdy = accept_ok[v];
  end

  assign req_vld   = found;
  assign req_vc    = win;
  assign req_ports = found ? pending[win] : '0;
  assign eff_gnt   = gnt_ports & req_ports;
  assign advance   = (eff_gnt != '0);
  assign rel_vld   = |pkt_done;
  assign rel_vc    = win;

  for (genvar g = 0; g < NVC; g++) begin : g_vc
    localparam bool_rsp = (g >= REQ_VCS);
    assign push[g] = in_vld && in_rdy && (in_vc == VC_W'(g));
    vca_vc_slot #(
      .PORTS  (PORTS),
      .DEPTH  (bool_rsp ? RSP_DEP : REQ_DEP),
      .PKT_LEN(bool_rsp ? RSP_LEN : REQ_LEN)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[g]),
      .push_route(in_route),
      .served    ((found && win == VC_W'(g)) ? eff_gnt : '0),
      .has_flit  (has_flit[g]),
      .pending   (pending[g]),
      .accept_ok (accept_ok[g]),
      .pkt_done  (pkt_done[g])
    );
  end

  vca_rr_pick #(.N(NVC), .IDX_W(VC_W)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (has_flit),
    .advance(advance),
    .found  (found),
    .win_idx(win)
  );
endmodule

// File: rtl/vca_checker.sv
module vca_checker #(
  parameter int PORTS = 5,
  parameter int VC_W  = 3,
  parameter int NVC   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic             in_rdy,
  input logic             req_vld,
  input logic [VC_W-1:0]  req_vc,
  input logic [PORTS-1:0] req_ports,
  input logic [PORTS-1:0] gnt_ports,
  input logic             rel_vld,
  input logic [VC_W-1:0]  rel_vc
);
  // R11
  req_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> (req_ports != '0));

  // R3
  vc_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> (int'(req_vc) < NVC));

  // R9
  rel_full_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_vld |-> (req_vld && rel_vc == req_vc && ((req_ports & ~gnt_ports) == '0)));

  // R5
  hold_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ((gnt_ports & req_ports) == '0) && !(in_vld && in_rdy))
    |=> (req_vld && $stable(req_vc) && $stable(req_ports)));

  // R6
  partial_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ((gnt_ports & req_ports) != '0) && ((req_ports & ~gnt_ports) != '0))
    |=> (!(req_vld && req_vc == $past(req_vc)) || req_ports == $past(req_ports & ~gnt_ports)));
endmodule

bind vc_mcast_arb vca_checker #(.PORTS(PORTS), .VC_W(VC_W), .NVC(NVC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
  .req_vld(req_vld), .req_vc(req_vc), .req_ports(req_ports),
  .gnt_ports(gnt_ports), .rel_vld(rel_vld), .rel_vc(rel_vc)
);

// File: tb/sim_vc_mcast_arb.sv
`timescale 1ns/1ps
module sim_vc_mcast_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic       in_rdy;
  logic [2:0] in_vc = '0;
  logic [4:0] in_route = '0;
  logic       req_vld;
  logic [2:0] req_vc;
  logic [4:0] req_ports;
  logic [4:0] gnt_ports = '0;
  logic       rel_vld;
  logic [2:0] rel_vc;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0, wd_hit = 1'b0;

  typedef struct {
    string      tag;
    logic       e_req;
    int         e_vc;
    logic [4:0] e_ports;
    logic       e_rel;
    int         e_relvc;
    logic       e_rdy;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  vc_mcast_arb u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy), .in_vc(in_vc),
    .in_route(in_route), .req_vld(req_vld), .req_vc(req_vc), .req_ports(req_ports),
    .gnt_ports(gnt_ports), .rel_vld(rel_vld), .rel_vc(rel_vc)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues what must be seen
  task automatic step(input string tag, input logic v, input int vc, input logic [4:0] rt,
                      input logic [4:0] g, input logic e_req, input int e_vc,
                      input logic [4:0] e_ports, input logic e_rel, input int e_relvc,
                      input logic e_rdy);
    exp_t e;
    @(posedge clk); #1;
    in_vld = v; in_vc = vc[2:0]; in_route = rt; gnt_ports = g;
    e.tag = tag; e.e_req = e_req; e.e_vc = e_vc; e.e_ports = e_ports;
    e.e_rel = e_rel; e.e_relvc = e_relvc; e.e_rdy = e_rdy;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "req_vld", int'(req_vld), int'(e.e_req));
      if (e.e_req) begin
        chk(e.tag, "req_vc", int'(req_vc), e.e_vc);
        chk(e.tag, "req_ports", int'(req_ports), int'(e.e_ports));
      end
      chk(e.tag, "rel_vld", int'(rel_vld), int'(e.e_rel));
      if (e.e_rel) chk(e.tag, "rel_vc", int'(rel_vc), e.e_relvc);
      chk(e.tag, "in_rdy", int'(in_rdy), int'(e.e_rdy));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 5000) wd_hit = 1'b1;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R1",  0, 0, 5'b00000, 5'b00000, 0, 0, 5'b00000, 0, 0, 1);
    // request class, multicast with partial grant
    step("R2",  1, 0, 5'b00011, 5'b00000, 0, 0, 5'b00000, 0, 0, 1);
    step("R3",  0, 0, 5'b00000, 5'b00000, 1, 0, 5'b00011, 0, 0, 0);
    step("R6",  0, 0, 5'b00000, 5'b00001, 1, 0, 5'b00011, 0, 0, 0);
    step("R6",  1, 1, 5'b10000, 5'b00000, 1, 0, 5'b00010, 0, 0, 1);
    step("R4",  0, 1, 5'b00000, 5'b00000, 1, 1, 5'b10000, 0, 0, 0);
    step("R7",  0, 1, 5'b00000, 5'b01100, 1, 1, 5'b10000, 0, 0, 0);
    step("R9",  0, 1, 5'b00000, 5'b10000, 1, 1, 5'b10000, 1, 1, 0);
    step("R8",  0, 0, 5'b00000, 5'b00010, 1, 0, 5'b00010, 1, 0, 0);
    step("R10", 0, 0, 5'b00000, 5'b00000, 0, 0, 5'b00000, 0, 0, 1);
    // response class, five-flit packet in a three-deep VC
    step("R2",  1, 4, 5'b00101, 5'b00000, 0, 0, 5'b00000, 0, 0, 1);
    step("R8",  1, 4, 5'b00000, 5'b00101, 1, 4, 5'b00101, 0, 0, 1);
    step("R8",  1, 4, 5'b00000, 5'b00000, 1, 4, 5'b00101, 0, 0, 1);
    step("R8",  1, 4, 5'b00000, 5'b00000, 1, 4, 5'b00101, 0, 0, 1);
    step("R10", 1, 4, 5'b00000, 5'b00000, 1, 4, 5'b00101, 0, 0, 0);
    step("R8",  0, 4, 5'b00000, 5'b00101, 1, 4, 5'b00101, 0, 0, 0);
    step("R10", 1, 4, 5'b00000, 5'b00101, 1, 4, 5'b00101, 0, 0, 1);
    step("R10", 0, 4, 5'b00000, 5'b00101, 1, 4, 5'b00101, 0, 0, 0);
    step("R9",  0, 4, 5'b00000, 5'b00101, 1, 4, 5'b00101, 1, 4, 0);
    step("R10", 0, 4, 5'b00000, 5'b00000, 0, 0, 5'b00000, 0, 0, 1);
    // round-robin order across classes
    step("R2",  1, 2, 5'b00001, 5'b00000, 0, 0, 5'b00000, 0, 0, 1);
    step("R4",  1, 3, 5'b00010, 5'b00000, 1, 2, 5'b00001, 0, 0, 1);
    step("R4",  1, 5, 5'b01000, 5'b00001, 1, 2, 5'b00001, 1, 2, 1);
    step("R4",  0, 3, 5'b00000, 5'b00010, 1, 3, 5'b00010, 1, 3, 0);
    step("R4",  0, 5, 5'b00000, 5'b01000, 1, 5, 5'b01000, 0, 0, 1);
    step("R5",  0, 0, 5'b00000, 5'b00000, 0, 0, 5'b00000, 0, 0, 1);
    @(posedge clk); #1;
    in_vld = 1'b0; gnt_ports = '0;
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done || wd_hit);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule